// File: doc/BRIEF.md
# Single-Channel Flyby DMA Engine

This block moves a block of data between a peripheral and memory without the CPU touching each word. Software programs a start address, a count word and a control word, then enables the channel. When the peripheral raises its request, the engine asks the CPU for the bus and waits for the grant. It then drives one memory address per cycle while acknowledging the peripheral. The peripheral itself drives or latches the data bus, so each transfer is a single memory cycle (flyby).

The count word holds the number of transfers minus one in its low bits and a two-bit operation code in the two bits above it. The operation code selects a memory write, a memory read or a verify cycle that asserts no strobe. Three transfer modes set how long the bus is held. Demand mode runs while the request stays high. Block mode moves the whole block in one bus tenure. Single mode returns the bus after every transfer.

At terminal count the engine releases the bus and sets a sticky flag that a status read clears. Without auto-initialization it disables the channel and pulses an interrupt. With auto-initialization it reloads the working address and count from their base copies and stays enabled.

Top module: `dma_channel`

## Requirements
- R1: After reset, bus_req, dev_ack, mem_rd, mem_wr, term_cnt and done_irq are low, and the control and status registers read zero while dev_req is low.
- R2: A request on dev_req with the channel enabled raises bus_req. dev_ack rises only on a later cycle after bus_grant has been seen high, and is high only while bus_req is high. With the channel disabled, a request leaves bus_req low.
- R3: During each transfer mem_addr equals the current address. The current address then steps by one, wrapping modulo 2^ADDR_W.
- R4: A block performs exactly count+1 transfers. term_cnt is high during the last transfer only. Without auto-initialization, the current count reads back as all ones afterwards.
- R5: The operation code is count-word bits [CNT_W+1:CNT_W]. Code 01 asserts mem_wr and code 10 asserts mem_rd, each only while dev_ack is high. Codes 00 and 11 assert neither.
- R6: In demand mode (control bits [3:2] = 00), transfers run on consecutive cycles while dev_req is high. If dev_req is low when a transfer ends, the bus is released, and the block resumes at the next request.
- R7: In block mode (01), the whole block runs on consecutive cycles in one bus tenure, even after dev_req falls.
- R8: In single mode (10, and also 11), each bus tenure carries one transfer, and dev_ack is never high on two consecutive cycles.
- R9: The cycle after the last transfer, bus_req and dev_ack are both low.
- R10: Without auto-initialization (control bit 1 = 0), terminal count clears the enable bit (control bit 0). It also raises done_irq for exactly the one cycle after the last transfer.
- R11: With auto-initialization, terminal count reloads the current address and count from their base values and keeps the channel enabled, with no interrupt. A further request runs the block again from the base address.
- R12: Status bit 0 is the terminal-count flag and bit 1 shows dev_req live. Reading the status register clears the flag, while reads of other registers leave it set.
- R13: Register select 0 is the address, 1 the count word, 2 the control word and 3 the status. Writes to selects 0 and 1 load both the base and the current copies. Reads of selects 0 and 1 return the current copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the status flag when select is 3) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the selected register |
| dev_req | input | 1 | Peripheral transfer request |
| bus_grant | input | 1 | Bus grant from the CPU |
| bus_req | output | 1 | Bus request to the CPU |
| dev_ack | output | 1 | Acknowledge to the peripheral, one transfer per high cycle |
| mem_addr | output | ADDR_W | Memory address of the current transfer |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| term_cnt | output | 1 | High during the final transfer of a block |
| done_irq | output | 1 | One-cycle interrupt at the end of a block without auto-initialization |

## Verification
The bench builds the engine with ADDR_W = 8, CNT_W = 6 and DATA_W = 8, so the count word fills the data width exactly, as it does at the default sizes. Under this configuration every combination of mode, operation code, short block length and auto-initialization setting can be swept. A full 64-transfer block can also start near the top of the address space, which brings both the count limit and the address wrap within reach in a few hundred cycles.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [1:0] {
        XM_DEMAND = 2'b00,
        XM_BLOCK  = 2'b01,
        XM_SINGLE = 2'b10,
        XM_SNGL_B = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        OP_VERIFY = 2'b00,
        OP_MEMWR  = 2'b01,
        OP_MEMRD  = 2'b10,
        OP_BAD    = 2'b11
    } xfer_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ASK  = 2'b01,
        ST_MOVE = 2'b10
    } seq_state_e;

    localparam logic [1:0] SEL_ADDR  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;
    localparam logic [1:0] SEL_STAT  = 2'd3;

endpackage

// File: rtl/dma_addr_cnt.sv
module dma_addr_cnt
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 14,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_addr,
    input  logic              ld_cnt,
    input  logic [DATA_W-1:0] wdata,
    input  logic              step,
    input  logic              auto_init,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  base_cnt,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              last
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
    } walk_t;

    walk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            if (st_q.cnt == '0 && auto_init) begin
                st_d.addr = base_addr;
                st_d.cnt  = base_cnt;
            end else begin
                st_d.addr = st_q.addr + 1'b1;
                st_d.cnt  = st_q.cnt - 1'b1;
            end
        end
        if (ld_addr) st_d.addr = wdata[ADDR_W-1:0];
        if (ld_cnt)  st_d.cnt  = wdata[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_addr = st_q.addr;
    assign cur_cnt  = st_q.cnt;
    assign last     = (st_q.cnt == '0);

    // R3: a plain step advances the address by one
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_addr && !(last && auto_init)) |=> cur_addr == $past(cur_addr) + 1'b1);

    // R11: the final step with auto-init restores the base address
    a_r11_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last && auto_init && !ld_addr) |=> cur_addr == $past(base_addr));

endmodule

// File: rtl/dma_regs.sv
module dma_regs
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 14,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dev_req,
    input  logic              tc_evt,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [CNT_W-1:0]  cur_cnt,
    output logic              chan_en,
    output logic              auto_init,
    output xfer_mode_e        mode,
    output xfer_op_e          op,
    output logic [ADDR_W-1:0] base_addr,
    output logic [CNT_W-1:0]  base_cnt,
    output logic              ld_addr,
    output logic              ld_cnt,
    output logic              done_irq
);

    typedef struct packed {
        logic [ADDR_W-1:0] base_addr;
        logic [CNT_W-1:0]  base_cnt;
        xfer_op_e          op;
        xfer_mode_e        mode;
        logic              auto_init;
        logic              en;
        logic              tc_flag;
        logic              irq;
    } regs_t;

    regs_t rg_d, rg_q;
    logic  wr_ctrl, rd_stat;

    assign ld_addr = reg_wr && (reg_sel == SEL_ADDR);
    assign ld_cnt  = reg_wr && (reg_sel == SEL_COUNT);
    assign wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);
    assign rd_stat = reg_rd && (reg_sel == SEL_STAT);

    always_comb begin
        rg_d     = rg_q;
        rg_d.irq = 1'b0;
        if (ld_addr) rg_d.base_addr = reg_wdata[ADDR_W-1:0];
        if (ld_cnt) begin
            rg_d.base_cnt = reg_wdata[CNT_W-1:0];
            rg_d.op       = xfer_op_e'(reg_wdata[CNT_W+1:CNT_W]);
        end
        if (wr_ctrl) begin
            rg_d.en        = reg_wdata[0];
            rg_d.auto_init = reg_wdata[1];
            rg_d.mode      = xfer_mode_e'(reg_wdata[3:2]);
        end
        if (rd_stat) rg_d.tc_flag = 1'b0;
        if (tc_evt) begin
            rg_d.tc_flag = 1'b1;
            if (!rg_q.auto_init) begin
                rg_d.en  = 1'b0;
                rg_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_ADDR:  reg_rdata[ADDR_W-1:0] = cur_addr;
            SEL_COUNT: begin
                reg_rdata[CNT_W-1:0]     = cur_cnt;
                reg_rdata[CNT_W+1:CNT_W] = rg_q.op;
            end
            SEL_CTRL: begin
                reg_rdata[0]   = rg_q.en;
                reg_rdata[1]   = rg_q.auto_init;
                reg_rdata[3:2] = rg_q.mode;
            end
            default: begin
                reg_rdata[0] = rg_q.tc_flag;
                reg_rdata[1] = dev_req;
            end
        endcase
    end

    assign chan_en   = rg_q.en;
    assign auto_init = rg_q.auto_init;
    assign mode      = rg_q.mode;
    assign op        = rg_q.op;
    assign base_addr = rg_q.base_addr;
    assign base_cnt  = rg_q.base_cnt;
    assign done_irq  = rg_q.irq;

    // R10: the interrupt never lasts two cycles
    a_r10_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    // R12: a status read without a new terminal count leaves the flag clear
    a_r12_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !tc_evt) |=> !rg_q.tc_flag);

    // R11: auto-init keeps the channel enabled across terminal count
    a_r11_stay_on: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_evt && auto_init && !wr_ctrl) |=> chan_en);

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  xfer_mode_e        mode,
    input  xfer_op_e          op,
    input  logic              dev_req,
    input  logic              bus_grant,
    input  logic              last,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic              bus_req,
    output logic              dev_ack,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              term_cnt,
    output logic              step
);

    typedef struct packed {
        seq_state_e state;
    } seq_t;

    seq_t sq_d, sq_q;

    always_comb begin
        sq_d = sq_q;
        case (sq_q.state)
            ST_IDLE: if (chan_en && dev_req) sq_d.state = ST_ASK;
            ST_ASK: begin
                if (!chan_en)       sq_d.state = ST_IDLE;
                else if (bus_grant) sq_d.state = ST_MOVE;
            end
            ST_MOVE: begin
                if (last) sq_d.state = ST_IDLE;
                else begin
                    case (mode)
                        XM_DEMAND: sq_d.state = dev_req ? ST_MOVE : ST_IDLE;
                        XM_BLOCK:  sq_d.state = ST_MOVE;
                        default:   sq_d.state = ST_IDLE;
                    endcase
                end
            end
            default: sq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '{state: ST_IDLE};
        else        sq_q <= sq_d;
    end

    assign bus_req  = (sq_q.state != ST_IDLE);
    assign dev_ack  = (sq_q.state == ST_MOVE);
    assign step     = dev_ack;
    assign term_cnt = dev_ack && last;
    assign mem_wr   = dev_ack && (op == OP_MEMWR);
    assign mem_rd   = dev_ack && (op == OP_MEMRD);
    assign mem_addr = cur_addr;

    // R2: acknowledge only inside a bus tenure
    a_r2_ack_in_tenure: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |-> bus_req);

    // R2: no acknowledge follows a cycle spent waiting without grant
    a_r2_wait_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.state == ST_ASK && !bus_grant) |=> !dev_ack);

    // R5: strobes only with acknowledge, never both
    a_r5_strobe_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> dev_ack);
    a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R9: the bus is handed back right after the final transfer
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        term_cnt |=> (!bus_req && !dev_ack));

    // R8: single mode never acknowledges back to back
    a_r8_single_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ack && mode[1]) |=> !dev_ack);

endmodule

// File: rtl/dma_channel.sv
module dma_channel
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 14,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dev_req,
    input  logic              bus_grant,
    output logic              bus_req,
    output logic              dev_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              term_cnt,
    output logic              done_irq
);

    logic              chan_en, auto_init, ld_addr, ld_cnt, step, last;
    xfer_mode_e        mode;
    xfer_op_e          op;
    logic [ADDR_W-1:0] base_addr, cur_addr;
    logic [CNT_W-1:0]  base_cnt, cur_cnt;

    dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dev_req   (dev_req),
        .tc_evt    (term_cnt),
        .cur_addr  (cur_addr),
        .cur_cnt   (cur_cnt),
        .chan_en   (chan_en),
        .auto_init (auto_init),
        .mode      (mode),
        .op        (op),
        .base_addr (base_addr),
        .base_cnt  (base_cnt),
        .ld_addr   (ld_addr),
        .ld_cnt    (ld_cnt),
        .done_irq  (done_irq)
    );

    dma_addr_cnt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_addr   (ld_addr),
        .ld_cnt    (ld_cnt),
        .wdata     (reg_wdata),
        .step      (step),
        .auto_init (auto_init),
        .base_addr (base_addr),
        .base_cnt  (base_cnt),
        .cur_addr  (cur_addr),
        .cur_cnt   (cur_cnt),
        .last      (last)
    );

    dma_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_en   (chan_en),
        .mode      (mode),
        .op        (op),
        .dev_req   (dev_req),
        .bus_grant (bus_grant),
        .last      (last),
        .cur_addr  (cur_addr),
        .bus_req   (bus_req),
        .dev_ack   (dev_ack),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .term_cnt  (term_cnt),
        .step      (step)
    );

endmodule

// File: tb/sim_dma_channel.sv
`timescale 1ns/100ps
module sim_dma_channel;

    localparam int AW = 8;
    localparam int CW = 6;
    localparam int DW = 8;
    localparam int AMASK = (1 << AW) - 1;
    localparam int CMASK = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    reg_sel = '0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          dev_req = 1'b0, bus_grant = 1'b0;
    logic          bus_req, dev_ack, mem_rd, mem_wr, term_cnt, done_irq;
    logic [AW-1:0] mem_addr;

    dma_channel #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dev_req(dev_req), .bus_grant(bus_grant), .bus_req(bus_req),
        .dev_ack(dev_ack), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .term_cnt(term_cnt), .done_irq(done_irq)
    );

    initial forever #2.5 clk = ~clk;

    int nchk = 0, nfail = 0;
    int nx = 0, exp_n = 0, exp_op = 0, exp_mode = 0, exp_auto = 0;
    int cyc = 0, first_cyc = 0, last_cyc = 0;
    logic [AW-1:0] exp_addr = '0;
    bit prev_ack = 0, prev_tc = 0, prev_hold = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    endtask

    // CPU model: grants the bus one half cycle after it is requested
    initial forever begin
        @(negedge clk);
        bus_grant = bus_req;
    end

    // transfer monitor
    initial forever begin
        @(negedge clk);
        #1;
        cyc++;
        if (bus_req && !prev_hold)
            chk(!dev_ack, "R2 ack with fresh request", int'(dev_ack), 0);
        if (prev_tc) begin
            chk(!bus_req && !dev_ack, "R9 release", int'(bus_req | dev_ack), 0);
            chk(done_irq == (exp_auto == 0), "R10/R11 irq", int'(done_irq), int'(exp_auto == 0));
        end
        if (dev_ack) begin
            chk(mem_addr == exp_addr, "R3 address", int'(mem_addr), int'(exp_addr));
            chk(mem_wr == (exp_op == 1) && mem_rd == (exp_op == 2), "R5 strobes",
                int'({mem_rd, mem_wr}), (exp_op == 1) ? 1 : (exp_op == 2) ? 2 : 0);
            chk(term_cnt == (nx == exp_n - 1), "R4 term_cnt", int'(term_cnt), int'(nx == exp_n - 1));
            if (exp_mode >= 2)
                chk(!prev_ack, "R8 back-to-back", 1, 0);
            if (nx == 0) first_cyc = cyc;
            last_cyc = cyc;
            exp_addr = exp_addr + 1'b1;
            nx++;
        end else begin
            chk(!mem_rd && !mem_wr && !term_cnt, "R5 idle strobes",
                int'({term_cnt, mem_rd, mem_wr}), 0);
        end
        prev_ack = dev_ack;
        prev_tc = term_cnt;
        prev_hold = bus_req;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_up();
    end

    task automatic wr(input int s, input int v);
        @(negedge clk);
        reg_sel = 2'(s);
        reg_wdata = DW'(v);
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int s, output int v);
        @(negedge clk);
        reg_sel = 2'(s);
        reg_rd = 1'b1;
        #1 v = int'(reg_rdata);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_nx(input int target);
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            #2;
            if (nx >= target) break;
        end
    endtask

    task automatic pass_blk(input int mode, input int n);
        nx = 0;
        dev_req = 1'b1;
        if (mode == 1) begin
            wait_nx(1);
            dev_req = 1'b0;
        end
        wait_nx(n);
        dev_req = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic run(input int mode, input int op, input int cntf,
                       input int start, input int auto);
        int v, n;
        n = cntf + 1;
        exp_mode = mode; exp_op = op; exp_auto = auto; exp_n = n;
        exp_addr = AW'(start);
        wr(0, start);
        wr(1, (op << CW) | cntf);
        wr(2, (mode << 2) | (auto << 1) | 1);
        pass_blk(mode, n);
        chk(nx == n, "R4 transfer count", nx, n);
        if (mode == 0) chk(last_cyc - first_cyc == n - 1, "R6 demand back-to-back", last_cyc - first_cyc, n - 1);
        if (mode == 1) chk(last_cyc - first_cyc == n - 1, "R7 block one tenure", last_cyc - first_cyc, n - 1);
        if (mode >= 2) chk(last_cyc - first_cyc >= 2 * (n - 1), "R8 single spacing", last_cyc - first_cyc, 2 * (n - 1));
        rd(2, v);
        chk(v == ((mode << 2) | (auto << 1) | auto), "R10/R11 control after tc", v, (mode << 2) | (auto << 1) | auto);
        rd(0, v);
        chk(v == (auto ? start : ((start + n) & AMASK)), "R11/R3 current address", v, auto ? start : ((start + n) & AMASK));
        rd(1, v);
        chk(v == ((op << CW) | (auto ? cntf : CMASK)), "R4/R13 current count", v, (op << CW) | (auto ? cntf : CMASK));
        rd(3, v);
        chk(v == 1, "R12 status after tc", v, 1);
        rd(3, v);
        chk(v == 0, "R12 status cleared by read", v, 0);
        if (auto) begin
            exp_addr = AW'(start);
            pass_blk(mode, n);
            chk(nx == n, "R11 rerun after reload", nx, n);
            wr(2, 0);
            rd(3, v);
            chk(v == 1, "R11 second block tc", v, 1);
        end
    endtask

    initial begin
        int v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!bus_req && !dev_ack && !mem_rd && !mem_wr && !term_cnt && !done_irq, "R1 outputs",
            int'({bus_req, dev_ack, mem_rd, mem_wr, term_cnt, done_irq}), 0);
        rd(2, v); chk(v == 0, "R1 control", v, 0);
        rd(3, v); chk(v == 0, "R1 status", v, 0);

        // disabled channel ignores a request, status shows it live
        dev_req = 1'b1;
        repeat (5) @(negedge clk);
        #1 chk(!bus_req, "R2 disabled ignores request", int'(bus_req), 0);
        rd(3, v); chk(v == 2, "R12 live request bit", v, 2);
        dev_req = 1'b0;

        // sweep of modes, operations, lengths, auto-init
        for (int m = 0; m < 4; m++)
            for (int o = 0; o < 4; o++)
                for (int c = 0; c < 3; c++)
                    for (int a = 0; a < 2; a++)
                        run(m, o, c, 16 * m + 4 * o + c, a);

        // full-length block across the address wrap
        run(0, 2, CMASK, 8'hF0, 0);

        // demand pause and resume
        exp_mode = 0; exp_op = 1; exp_auto = 0; exp_n = 6;
        exp_addr = 8'h40;
        wr(0, 8'h40);
        wr(1, (1 << CW) | 5);
        wr(2, 1);
        nx = 0;
        dev_req = 1'b1;
        wait_nx(2);
        dev_req = 1'b0;
        repeat (6) @(negedge clk);
        #1;
        chk(nx == 2, "R6 pause when request drops", nx, 2);
        chk(!bus_req, "R6 bus released in pause", int'(bus_req), 0);
        dev_req = 1'b1;
        wait_nx(6);
        dev_req = 1'b0;
        repeat (4) @(negedge clk);
        chk(nx == 6, "R6 resumed block completes", nx, 6);
        rd(0, v); chk(v == 8'h46, "R6 address after resume", v, 8'h46);

        finish_up();
    end

endmodule